// File: doc/BRIEF.md
# Stage-1/Stage-2 Access Permission Checker

This block decides whether one memory access may proceed against the permission bits of a single translation entry. It takes the entry's access-permission pair, its two execute-never bits and its stage-2 permission pair. It also takes the kind of access, the current exception level, a stage-2 select and a small set of control bits: write-implies-execute-never, the privileged-access-never state and its feature enable, and the EL2 host bit. From these it produces a grant, a fault flag and the write-not-read bit that a fault syndrome would carry.

The decision is computed combinationally and registered once, so the verdict for the inputs presented at one rising edge appears on the outputs after that edge. The stage-1 decode is held as explicit per-level case tables. Any index the tables do not name resolves to no permission. Several rules shape the write-not-read bit: cache-clean requests count as reads, and atomic accesses report a read whenever a plain read would also have faulted.

Top module: `ap_perm_chk`

## Requirements
- R1: While rst_n is low at a rising edge, acc_ok, acc_fault and flt_wnr are all 0 after that edge.
- R2: The verdict for the inputs present at a rising edge with rst_n high appears after that edge. acc_fault is the inverse of acc_ok. flt_wnr is 0 whenever acc_ok is 1.
- R3: With s2_mode=1, a read (acc_kind=2'b00) is granted exactly when ent_hap[0]=1, and a write (acc_kind=2'b01) is granted exactly when ent_hap[1]=1.
- R4: With s2_mode=1, a fetch (acc_kind=2'b10) is granted only when ctl_wxn=0 and ent_xn=0.
- R5: Stage 1 at EL0 (cur_el=0): a read needs ent_ap[0]=1, and a write needs ent_ap=2'b01. A fetch needs ent_xn=0, and when ctl_wxn=1 it also needs the page not to be EL0-writable.
- R6: Stage 1 at EL1: reads are always allowed, and writes need ent_ap[1]=0. A fetch needs ent_pxn=0 and ent_ap!=2'b01, and when ctl_wxn=1 it also needs ent_ap[1]=1.
- R7: Stage 1 at EL2 or EL3: the decode uses only ent_ap[1] and ent_xn. Reads are always allowed, and writes need ent_ap[1]=0. A fetch needs ent_xn=0, and when ctl_wxn=1 it also needs ent_ap[1]=1.
- R8: A cache-clean request (cmo_clean=1) with cur_el!=0 and s2_mode=0 is granted with no fault, whatever its kind, permissions or misalignment.
- R9: Any other cache-clean request is checked as a read even when acc_kind=2'b01, and its fault never reports a write.
- R10: The PAN override denies the access and clears the syndrome read-grant when all of the following hold: feat_pan=1, ctl_pan=1, ent_ap[0]=1, the access is not a fetch, and either cmo_maint=0 or cmo_zero=1. It applies only at stage 1, at EL1, or at EL2 with ctl_e2h=1.
- R11: A permission fault on a write reports flt_wnr=1, except for an atomic write (acc_atomic=1) whose syndrome read-grant is 0. That case reports 0. The syndrome read-grant is ent_hap[0] at stage 2, ent_ap[0] at EL0, and 1 otherwise unless R10 fires.
- R12: A misaligned non-fetch access (acc_misalign=1) faults, with flt_wnr = write and not atomic. acc_misalign is ignored for fetches.
- R13: acc_kind=2'b11 is a reserved code and is never granted, except under R8. Its fault reports flt_wnr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 reserved |
| acc_atomic | input | 1 | Access is an atomic read-modify-write |
| cmo_clean | input | 1 | Cache-clean maintenance request |
| cmo_maint | input | 1 | Any cache-maintenance request |
| cmo_zero | input | 1 | Maintenance request zeroes a block |
| acc_misalign | input | 1 | Address fails the alignment rule |
| cur_el | input | 2 | Exception level 0..3 |
| s2_mode | input | 1 | Check against stage-2 permissions |
| ent_ap | input | 2 | Entry permission pair: bit0 lower-level access, bit1 read-only |
| ent_xn | input | 1 | Entry execute-never (unprivileged at EL0/EL1) |
| ent_pxn | input | 1 | Entry privileged execute-never |
| ent_hap | input | 2 | Stage-2 permission pair: bit0 read, bit1 write |
| ctl_wxn | input | 1 | Writable implies execute-never |
| ctl_pan | input | 1 | Privileged-access-never state |
| feat_pan | input | 1 | Privileged-access-never feature present |
| ctl_e2h | input | 1 | EL2 hosts an OS |
| acc_ok | output | 1 | Access granted |
| acc_fault | output | 1 | Access faults |
| flt_wnr | output | 1 | Fault reports a write |

## Verification
The PAN override and the atomic syndrome rule can act on the same access. An atomic write at EL1 to a page with ent_ap[0]=1 and PAN active is both denied by the override and has its read-grant cleared, so the syndrome must say read even though the page is writable. The bench drives that combination directly, along with the pairing of a misaligned access and a cache-clean bypass, and judges the registered outputs one edge later against a behavioural model. A long pseudo-random sweep over every input field then makes these collisions, and many others, recur.

// File: rtl/ap_perm_pkg.sv
// Shared types for the access permission checker.
// Assumes the two-bit access code and rwx permission triple below.
package ap_perm_pkg;
    localparam int EL_W  = 2;
    localparam int AP_W  = 2;
    localparam int IDX_W = AP_W + 2;

    typedef enum logic [1:0] {
        ACC_RD  = 2'b00,
        ACC_WR  = 2'b01,
        ACC_EX  = 2'b10,
        ACC_RSV = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } rwx_t;
endpackage

// File: rtl/ap_perm_s1_tbl.sv
// Stage-1 permission decode for one exception level.
// Holds explicit case tables per level; unnamed indices give no permission.
// Assumes ent_ap bit0 = lower-level access, bit1 = read-only.
module ap_perm_s1_tbl
    import ap_perm_pkg::*;
(
    input  logic [EL_W-1:0] el,
    input  logic [AP_W-1:0] ap,
    input  logic            xn,
    input  logic            pxn,
    input  logic            wxn,
    output rwx_t            perm,
    output logic            rd_syn
);
    localparam int LVL_N = 1 << EL_W;

    logic [IDX_W-1:0] idx_lo;
    logic [1:0]       idx_hi;
    rwx_t             raw [LVL_N];

    assign idx_lo = {ap, xn, pxn};
    assign idx_hi = {ap[1], xn};

    // EL0 table indexed by {ap, xn, pxn}
    always_comb begin
        case (idx_lo)
            4'd0, 4'd1, 4'd8, 4'd9:     raw[0] = 3'b001;
            4'd4, 4'd5:                 raw[0] = 3'b111;
            4'd6, 4'd7:                 raw[0] = 3'b110;
            4'd12, 4'd13:               raw[0] = 3'b101;
            4'd14, 4'd15:               raw[0] = 3'b100;
            default:                    raw[0] = 3'b000;
        endcase
    end

    // EL1 table indexed by {ap, xn, pxn}
    always_comb begin
        case (idx_lo)
            4'd0, 4'd2:                 raw[1] = 3'b111;
            4'd1, 4'd3:                 raw[1] = 3'b110;
            4'd4, 4'd5, 4'd6, 4'd7:     raw[1] = 3'b110;
            4'd8, 4'd10, 4'd12, 4'd14:  raw[1] = 3'b101;
            4'd9, 4'd11, 4'd13, 4'd15:  raw[1] = 3'b100;
            default:                    raw[1] = 3'b000;
        endcase
    end

    // EL2 and EL3 share a table indexed by {ap[1], xn}
    for (genvar g = 2; g < LVL_N; g++) begin : g_hi_lvl
        always_comb begin
            case (idx_hi)
                2'd0:    raw[g] = 3'b111;
                2'd1:    raw[g] = 3'b110;
                2'd2:    raw[g] = 3'b101;
                2'd3:    raw[g] = 3'b100;
                default: raw[g] = 3'b000;
            endcase
        end
    end

    // Select the level and apply write-implies-execute-never
    always_comb begin
        perm   = raw[el];
        perm.x = perm.x & ~(wxn & perm.w);
        rd_syn = (el == '0) ? ap[0] : 1'b1;
    end
endmodule

// File: rtl/ap_perm_s2_chk.sv
// Stage-2 permission decode from the entry's stage-2 pair.
// Assumes hap bit0 grants read, bit1 grants write.
module ap_perm_s2_chk
    import ap_perm_pkg::*;
(
    input  logic [AP_W-1:0] hap,
    input  logic            xn,
    input  logic            wxn,
    output rwx_t            perm,
    output logic            rd_syn
);
    // Map stage-2 bits onto the rwx triple
    always_comb begin
        perm.r = hap[0];
        perm.w = hap[1];
        perm.x = ~wxn & ~xn;
        rd_syn = hap[0];
    end
endmodule

// File: rtl/ap_perm_pan_gate.sv
// Detects when the privileged-access-never rule blocks a data access.
// Level and stage qualification is left to the caller.
module ap_perm_pan_gate (
    input  logic feat,
    input  logic state,
    input  logic ap_low,
    input  logic is_fetch,
    input  logic maint,
    input  logic zero_blk,
    output logic fire
);
    // All conditions must hold at once
    always_comb begin
        fire = feat & state & ap_low & ~is_fetch & (~maint | zero_blk);
    end
endmodule

// File: rtl/ap_perm_chk.sv
// Access permission checker: combines stage-1 tables, stage-2 bits,
// the PAN override, cache-clean rules, alignment and syndrome rules,
// and registers grant, fault and write-not-read once.
// Assumes synchronous active-low reset; outputs follow inputs by one edge.
module ap_perm_chk
    import ap_perm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      acc_kind,
    input  logic            acc_atomic,
    input  logic            cmo_clean,
    input  logic            cmo_maint,
    input  logic            cmo_zero,
    input  logic            acc_misalign,
    input  logic [EL_W-1:0] cur_el,
    input  logic            s2_mode,
    input  logic [AP_W-1:0] ent_ap,
    input  logic            ent_xn,
    input  logic            ent_pxn,
    input  logic [AP_W-1:0] ent_hap,
    input  logic            ctl_wxn,
    input  logic            ctl_pan,
    input  logic            feat_pan,
    input  logic            ctl_e2h,
    output logic            acc_ok,
    output logic            acc_fault,
    output logic            flt_wnr
);
    acc_kind_e kind;
    rwx_t      s1_perm, s2_perm, eff_perm;
    logic      s1_rd, s2_rd, eff_rd;
    logic      pan_raw, pan_hit;
    logic      is_rd, is_wr, is_ex;
    logic      bypass, align_hit, perm_ok;
    logic      ok_d, wnr_d;

    assign kind = acc_kind_e'(acc_kind);

    ap_perm_s1_tbl u_s1 (
        .el(cur_el), .ap(ent_ap), .xn(ent_xn), .pxn(ent_pxn),
        .wxn(ctl_wxn), .perm(s1_perm), .rd_syn(s1_rd)
    );

    ap_perm_s2_chk u_s2 (
        .hap(ent_hap), .xn(ent_xn), .wxn(ctl_wxn),
        .perm(s2_perm), .rd_syn(s2_rd)
    );

    ap_perm_pan_gate u_pan (
        .feat(feat_pan), .state(ctl_pan), .ap_low(ent_ap[0]),
        .is_fetch(kind == ACC_EX), .maint(cmo_maint),
        .zero_blk(cmo_zero), .fire(pan_raw)
    );

    // Classify the access; a clean is checked as a read
    always_comb begin
        is_wr = (kind == ACC_WR) & ~cmo_clean;
        is_rd = (kind == ACC_RD) | ((kind == ACC_WR) & cmo_clean);
        is_ex = (kind == ACC_EX);
    end

    // Pick the stage and apply the PAN override where it is in force
    always_comb begin
        pan_hit = pan_raw & ~s2_mode &
                  ((cur_el == 2'd1) | ((cur_el == 2'd2) & ctl_e2h));
        eff_perm = s2_mode ? s2_perm : s1_perm;
        eff_rd   = s2_mode ? s2_rd   : s1_rd;
        if (pan_hit) begin
            eff_perm = '0;
            eff_rd   = 1'b0;
        end
    end

    // Final verdict and syndrome write bit
    always_comb begin
        bypass    = cmo_clean & (cur_el != '0) & ~s2_mode;
        align_hit = acc_misalign & ~is_ex;
        perm_ok   = (is_rd & eff_perm.r) | (is_wr & eff_perm.w) |
                    (is_ex & eff_perm.x);
        ok_d      = bypass | (~align_hit & perm_ok);
        if (ok_d)
            wnr_d = 1'b0;
        else if (align_hit)
            wnr_d = is_wr & ~acc_atomic;
        else
            wnr_d = is_wr & ~(acc_atomic & ~eff_rd);
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_ok    <= 1'b0;
            acc_fault <= 1'b0;
            flt_wnr   <= 1'b0;
        end else begin
            acc_ok    <= ok_d;
            acc_fault <= ~ok_d;
            flt_wnr   <= wnr_d;
        end
    end

    // R3: stage-2 read follows the read bit of the stage-2 pair
    a_r3_s2_read: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_mode && acc_kind == 2'b00 && !acc_misalign && !cmo_clean)
        |=> (acc_ok == $past(ent_hap[0])));

    // R4: stage-2 fetch denied by either execute-never control
    a_r4_s2_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_mode && acc_kind == 2'b10 && (ctl_wxn || ent_xn))
        |=> acc_fault);

    // R8: clean above EL0 at stage 1 always passes
    a_r8_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cmo_clean && cur_el != 2'd0 && !s2_mode)
        |=> (acc_ok && !flt_wnr));

    // R10: PAN blocks a plain read at EL1
    a_r10_pan_el1: assert property (@(posedge clk) disable iff (!rst_n)
        (feat_pan && ctl_pan && ent_ap[0] && acc_kind == 2'b00 &&
         !cmo_maint && !cmo_clean && !s2_mode && cur_el == 2'd1 &&
         !acc_misalign)
        |=> acc_fault);

    // R11: a reported write always came from a non-clean write
    a_r11_wnr_source: assert property (@(posedge clk) disable iff (!rst_n)
        flt_wnr |-> $past(acc_kind == 2'b01 && !cmo_clean));

    // R12: misaligned atomic reports not-write
    a_r12_align_atomic: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_misalign && acc_atomic && acc_kind != 2'b10 &&
         !(cmo_clean && cur_el != 2'd0 && !s2_mode))
        |=> (acc_fault && !flt_wnr));
endmodule

// File: tb/ap_perm_chk_tb_top.sv
// Bench for ap_perm_chk: behavioural model compared after every edge.
module ap_perm_chk_tb_top;
    typedef struct packed {
        logic [1:0] kind;
        logic       atomic;
        logic       clean;
        logic       maint;
        logic       zero;
        logic       mis;
        logic [1:0] el;
        logic       s2;
        logic [1:0] ap;
        logic       xn;
        logic       pxn;
        logic [1:0] hap;
        logic       wxn;
        logic       pan;
        logic       feat;
        logic       e2h;
    } vec_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    vec_t v;
    logic acc_ok, acc_fault, flt_wnr;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    ap_perm_chk dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_kind(v.kind), .acc_atomic(v.atomic), .cmo_clean(v.clean),
        .cmo_maint(v.maint), .cmo_zero(v.zero), .acc_misalign(v.mis),
        .cur_el(v.el), .s2_mode(v.s2), .ent_ap(v.ap), .ent_xn(v.xn),
        .ent_pxn(v.pxn), .ent_hap(v.hap), .ctl_wxn(v.wxn),
        .ctl_pan(v.pan), .feat_pan(v.feat), .ctl_e2h(v.e2h),
        .acc_ok(acc_ok), .acc_fault(acc_fault), .flt_wnr(flt_wnr)
    );

    // Expected {ok, fault, wnr} from the requirements
    function automatic logic [2:0] model(vec_t t);
        bit rd, wr, ex, cr, cw, cx, syn, pan_on, ok;
        if (t.clean && t.el != 0 && !t.s2) return 3'b100;
        wr = (t.kind == 1) && !t.clean;
        rd = (t.kind == 0) || (t.kind == 1 && t.clean);
        ex = (t.kind == 2);
        if (t.mis && !ex) return {2'b01, wr && !t.atomic};
        if (t.s2) begin
            cr = t.hap[0]; cw = t.hap[1]; cx = !t.wxn && !t.xn; syn = t.hap[0];
        end else if (t.el == 0) begin
            cr = t.ap[0]; cw = (t.ap == 2'b01);
            cx = !t.xn && !(t.wxn && cw); syn = t.ap[0];
        end else if (t.el == 1) begin
            cr = 1; cw = !t.ap[1];
            cx = !t.pxn && t.ap != 2'b01 && !(t.wxn && cw); syn = 1;
        end else begin
            cr = 1; cw = !t.ap[1]; cx = !t.xn && !(t.wxn && cw); syn = 1;
        end
        pan_on = t.feat && t.pan && t.ap[0] && !ex && (!t.maint || t.zero) &&
                 !t.s2 && (t.el == 1 || (t.el == 2 && t.e2h));
        if (pan_on) begin cr = 0; cw = 0; cx = 0; syn = 0; end
        ok = (rd && cr) || (wr && cw) || (ex && cx);
        if (ok) return 3'b100;
        return {2'b01, wr && !(t.atomic && !syn)};
    endfunction

    task automatic compare(logic [2:0] exp, string tag);
        n_chk++;
        if ({acc_ok, acc_fault, flt_wnr} !== exp) begin
            n_bad++;
            $display("FAIL %s: got ok/fault/wnr=%b expected %b (vec %h)",
                     tag, {acc_ok, acc_fault, flt_wnr}, exp, v);
        end
    endtask

    // Drive at the falling edge, judge just after the next rising edge
    task automatic run(vec_t t, string tag);
        @(negedge clk);
        v = t;
        @(posedge clk);
        #1;
        compare(model(t), tag);
    endtask

    function automatic vec_t base(logic [1:0] kind, logic [1:0] el);
        vec_t t = '0;
        t.kind = kind;
        t.el = el;
        return t;
    endfunction

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        vec_t t;
        v = '1;
        repeat (3) @(posedge clk);
        #1;
        compare(3'b000, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: simple grant then fault, verdict after one edge
        t = base(2'b00, 2'd1);                  run(t, "R2 el1 read ok");
        t = base(2'b01, 2'd1); t.ap = 2'b10;    run(t, "R2 el1 ro write");

        // R3 / R4: stage 2
        t = base(2'b00, 2'd1); t.s2 = 1; t.hap = 2'b01; run(t, "R3 s2 read ok");
        t.hap = 2'b10;                                  run(t, "R3 s2 read deny");
        t.kind = 2'b01;                                 run(t, "R3 s2 write ok");
        t.hap = 2'b01;                                  run(t, "R3 s2 write deny");
        t.kind = 2'b10; t.hap = 2'b00;                  run(t, "R4 s2 fetch ok");
        t.wxn = 1;                                      run(t, "R4 s2 fetch wxn");
        t.wxn = 0; t.xn = 1;                            run(t, "R4 s2 fetch xn");

        // R5 / R6 / R7: full stage-1 tables for every level and kind
        for (int el = 0; el < 4; el++)
            for (int k = 0; k < 3; k++)
                for (int i = 0; i < 32; i++) begin
                    t = base(2'(k), 2'(el));
                    {t.ap, t.xn, t.pxn, t.wxn} = 5'(i);
                    run(t, el == 0 ? "R5 el0 table" :
                           el == 1 ? "R6 el1 table" : "R7 el2/3 table");
                end

        // R8 / R9: cache clean
        t = base(2'b01, 2'd1); t.clean = 1; t.maint = 1; t.ap = 2'b10;
        t.mis = 1;                                  run(t, "R8 clean bypass");
        t.el = 0; t.mis = 0; t.ap = 2'b11;          run(t, "R9 clean el0 as read");
        t.ap = 2'b10;                               run(t, "R9 clean el0 no wnr");
        t.el = 1; t.s2 = 1; t.hap = 2'b01;          run(t, "R9 clean s2 as read");

        // R10: PAN override
        t = base(2'b00, 2'd1); t.feat = 1; t.pan = 1; t.ap = 2'b01;
        run(t, "R10 pan el1 read");
        t.feat = 0;                                 run(t, "R10 no feature");
        t.feat = 1; t.el = 2;                       run(t, "R10 el2 no e2h");
        t.e2h = 1;                                  run(t, "R10 el2 e2h");
        t.el = 1; t.maint = 1;                      run(t, "R10 maint exempt");
        t.zero = 1;                                 run(t, "R10 zero block");
        t = base(2'b10, 2'd1); t.feat = 1; t.pan = 1; t.ap = 2'b11;
        run(t, "R10 fetch exempt");

        // R11: syndrome, including PAN plus atomic in one access
        t = base(2'b01, 2'd1); t.ap = 2'b10;        run(t, "R11 write wnr");
        t.atomic = 1;                               run(t, "R11 atomic ro el1");
        t = base(2'b01, 2'd1); t.feat = 1; t.pan = 1; t.ap = 2'b01;
        t.atomic = 1;                               run(t, "R11 pan+atomic");
        t.atomic = 0;                               run(t, "R11 pan write");
        t = base(2'b01, 2'd0); t.ap = 2'b10; t.atomic = 1;
        run(t, "R11 atomic el0 noread");

        // R12: alignment
        t = base(2'b01, 2'd1); t.mis = 1;           run(t, "R12 mis write");
        t.atomic = 1;                               run(t, "R12 mis atomic");
        t = base(2'b10, 2'd1); t.mis = 1;           run(t, "R12 fetch ignores mis");

        // R13: reserved kind
        t = base(2'b11, 2'd3);                      run(t, "R13 reserved");
        t.s2 = 1; t.hap = 2'b11;                    run(t, "R13 reserved s2");

        // Sweep over all fields
        for (int n = 0; n < 6000; n++) begin
            t = vec_t'($urandom);
            run(t, "R2 sweep");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule